// File: doc/BRIEF.md
# Accumulator ALU with Packed Status Flags

This block is the 8-bit arithmetic and logic stage of a small accumulator processor. Each cycle the surrounding core presents an operation code, operand A (the accumulator value), and operand B (the other source, or the register being incremented or decremented). The block returns the 8-bit result and a write-enable that tells the core whether the result is to be stored. It also returns the packed next-flag byte that the operation produces. The result, the write-enable and the next-flag byte are combinational.

Four status flags are held in a register inside the block: zero (Z), subtract (N), half-carry out of bit 3 (H) and carry (C). Every operation reads these registered flags as its flag inputs. The register is updated on the clock edge when an operation strobe is present. The core can also read the register as a packed byte and load it directly, for example when restoring a saved status word. When a load and an operation strobe arrive in the same cycle, the load decides the register contents.

Top module: `acc_alu`

## Requirements
- R1: Operation codes 0 (add) and 1 (add with carry-in C) write A+B(+C) and produce N=0, C=carry out of bit 7, H=carry out of bit 3, Z=1 when the 8-bit result is zero.
- R2: Codes 2 (subtract) and 3 (subtract with borrow-in C) write A-B(-C) and produce N=1, C=borrow out of bit 7, H=borrow out of bit 3 (from bit 4), Z=1 when the result is zero.
- R3: Code 7 (compare) produces exactly the flags of code 2, and result_we stays 0; result shows A-B.
- R4: Codes 4 (AND), 5 (XOR) and 6 (OR) write the bitwise result with N=0 and Z from the result; AND gives H=1, C=0; XOR and OR give H=0, C=0.
- R5: Codes 8 (increment) and 9 (decrement) write B+1 or B-1, set Z and H from that step, give N=0 for increment and N=1 for decrement, and keep C.
- R6: Code 10 writes the complement of A and sets H=1 and N=1, keeping Z and C. Code 11 gives C=1, H=0, N=0. Code 12 inverts C and clears H and N. Codes 11 and 12 keep Z, do not write (result_we=0), and put A on result.
- R7: Code 13 (decimal adjust of A) forms an offset of 0x06 when H=1, or when N=0 and A[3:0]>9. It adds 0x60 to the offset and sets C when C=1, or when N=0 and A>0x99. It writes A-offset when N=1 and A+offset otherwise, clears H, sets Z from the result and keeps N.
- R8: The packed flag byte has Z at bit 7, N at bit 6, H at bit 5 and C at bit 4; a load copies those bits of flag_wdata into the register.
- R9: Bits 3:0 of flag_byte and flag_next always read 0, and bits 3:0 of flag_wdata have no effect.
- R10: The flag register resets to Z=1, N=0, H=1, C=1 (byte 0xB0) and changes only on a clock edge with op_valid or flag_load high; result_we is 0 while op_valid is low.
- R11: When flag_load and op_valid are both high, the register takes the loaded value; result and result_we still follow the operation.
- R12: Codes 14 and 15 are no-ops: result_we=0, result=A, and the flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation strobe; flags update at the next edge |
| op_code | input | 4 | Operation code (see requirements) |
| opnd_a | input | 8 | Accumulator operand |
| opnd_b | input | 8 | Second operand, also the increment/decrement source |
| flag_load | input | 1 | Load the flag register from flag_wdata |
| flag_wdata | input | 8 | Packed flag byte to load |
| result | output | 8 | Combinational result |
| result_we | output | 1 | Result is to be written back |
| flag_next | output | 8 | Combinational packed flags the current operation produces |
| flag_byte | output | 8 | Registered packed flags |

## Verification
The only internal state is the four-bit flag register. A wrong flag value there shows up on flag_byte one edge after the update that caused it. Within the same cycle it also changes the outcome of every operation that reads a flag: add/subtract with carry, increment/decrement carry-keep, complement-carry and the decimal adjust. Each table vector first loads a known flag byte, then applies one operation and compares the combinational outputs. It compares flag_byte again after the following edge, so a stale or misrouted flag is caught on the next edge.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  localparam int unsigned W     = 8;
  localparam int unsigned NIB   = W / 2;
  localparam int unsigned OPW   = 4;
  localparam int unsigned FLW   = 4;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBC  = 4'd3,
    OP_AND  = 4'd4,
    OP_XOR  = 4'd5,
    OP_OR   = 4'd6,
    OP_CP   = 4'd7,
    OP_INC  = 4'd8,
    OP_DEC  = 4'd9,
    OP_CPL  = 4'd10,
    OP_SCF  = 4'd11,
    OP_CCF  = 4'd12,
    OP_DAA  = 4'd13,
    OP_RSV0 = 4'd14,
    OP_RSV1 = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic z;
    logic n;
    logic h;
    logic c;
  } flags_t;

  localparam flags_t FLAGS_RST = '{z: 1'b1, n: 1'b0, h: 1'b1, c: 1'b1};

  // Sum with carry-in; returns {carry out of MSB, carry out of low nibble, sum}
  function automatic logic [W+1:0] add_w(input logic [W-1:0] x, input logic [W-1:0] y,
                                         input logic ci);
    logic [W:0]   full;
    logic [NIB:0] low;
    full = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
    low  = {1'b0, x[NIB-1:0]} + {1'b0, y[NIB-1:0]} + {{NIB{1'b0}}, ci};
    return {full[W], low[NIB], full[W-1:0]};
  endfunction

  // Difference with borrow-in; returns {borrow out of MSB, borrow from upper nibble, diff}
  function automatic logic [W+1:0] sub_w(input logic [W-1:0] x, input logic [W-1:0] y,
                                         input logic bi);
    logic [W:0]   full;
    logic [NIB:0] low;
    full = {1'b0, x} - {1'b0, y} - {{W{1'b0}}, bi};
    low  = {1'b0, x[NIB-1:0]} - {1'b0, y[NIB-1:0]} - {{NIB{1'b0}}, bi};
    return {full[W], low[NIB], full[W-1:0]};
  endfunction

  // Decimal correction offset and new carry; returns {carry, offset}
  function automatic logic [W:0] bcd_offset(input logic [W-1:0] x, input flags_t f);
    logic [W-1:0] ofs;
    logic         cy;
    ofs = '0;
    if (f.h || (!f.n && x[NIB-1:0] > NIB'(9))) ofs = ofs | W'(8'h06);
    cy = f.c || (!f.n && x > W'(8'h99));
    if (cy) ofs = ofs | W'(8'h60);
    return {cy, ofs};
  endfunction

endpackage

// File: rtl/alu_arith.sv
module alu_arith
  import acc_alu_pkg::*;
(
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           c_in,
  output logic [W-1:0]   res,
  output flags_t         flg,
  output logic           half_ev,
  output logic           carry_ev
);

  logic [W+1:0] raw;
  logic         keep_c;
  logic         is_sub;

  always_comb begin
    keep_c = 1'b0;
    is_sub = 1'b0;
    unique case (op)
      OP_ADD:        raw = add_w(a, b, 1'b0);
      OP_ADC:        raw = add_w(a, b, c_in);
      OP_SUB, OP_CP: begin raw = sub_w(a, b, 1'b0); is_sub = 1'b1; end
      OP_SBC:        begin raw = sub_w(a, b, c_in); is_sub = 1'b1; end
      OP_INC:        begin raw = add_w(b, W'(1), 1'b0); keep_c = 1'b1; end
      OP_DEC:        begin raw = sub_w(b, W'(1), 1'b0); keep_c = 1'b1; is_sub = 1'b1; end
      default:       raw = add_w(a, b, 1'b0);
    endcase
  end

  assign res      = raw[W-1:0];
  assign half_ev  = raw[W];
  assign carry_ev = raw[W+1];

  assign flg.z = (res == '0);
  assign flg.n = is_sub;
  assign flg.h = half_ev;
  assign flg.c = keep_c ? c_in : carry_ev;

endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import acc_alu_pkg::*;
(
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           z_in,
  input  logic           c_in,
  output logic [W-1:0]   res,
  output flags_t         flg
);

  always_comb begin
    res = a;
    flg = '{z: z_in, n: 1'b0, h: 1'b0, c: c_in};
    unique case (op)
      OP_AND: begin res = a & b; flg = '{z: ((a & b) == '0), n: 1'b0, h: 1'b1, c: 1'b0}; end
      OP_XOR: begin res = a ^ b; flg = '{z: ((a ^ b) == '0), n: 1'b0, h: 1'b0, c: 1'b0}; end
      OP_OR:  begin res = a | b; flg = '{z: ((a | b) == '0), n: 1'b0, h: 1'b0, c: 1'b0}; end
      OP_CPL: begin res = ~a;    flg = '{z: z_in, n: 1'b1, h: 1'b1, c: c_in}; end
      OP_SCF: flg = '{z: z_in, n: 1'b0, h: 1'b0, c: 1'b1};
      OP_CCF: flg = '{z: z_in, n: 1'b0, h: 1'b0, c: ~c_in};
      default: ;
    endcase
  end

endmodule

// File: rtl/alu_bcd.sv
module alu_bcd
  import acc_alu_pkg::*;
(
  input  logic [W-1:0]   a,
  input  logic           n_in,
  input  logic           h_in,
  input  logic           c_in,
  output logic [W-1:0]   res,
  output flags_t         flg,
  output logic [W-1:0]   offset
);

  logic [W:0] adj;
  logic       cy_new;

  assign adj    = bcd_offset(a, '{z: 1'b0, n: n_in, h: h_in, c: c_in});
  assign offset = adj[W-1:0];
  assign cy_new = adj[W];
  assign res    = n_in ? (a - offset) : (a + offset);

  assign flg.z = (res == '0);
  assign flg.n = n_in;
  assign flg.h = 1'b0;
  assign flg.c = cy_new;

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           op_valid,
  input  logic [3:0]     op_code,
  input  logic [7:0]     opnd_a,
  input  logic [7:0]     opnd_b,
  input  logic           flag_load,
  input  logic [7:0]     flag_wdata,
  output logic [7:0]     result,
  output logic           result_we,
  output logic [7:0]     flag_next,
  output logic [7:0]     flag_byte
);

  localparam int unsigned PAD = W - FLW;

  alu_op_e      op;
  flags_t       flg_q;
  flags_t       flg_nxt;
  flags_t       ar_flg, lg_flg, bc_flg;
  logic [W-1:0] ar_res, lg_res, bc_res, bc_ofs;
  logic         ar_half, ar_carry;
  logic         cls_arith, cls_logic, cls_bcd;
  logic         op_writes;

  assign op = alu_op_e'(op_code);

  always_comb begin
    cls_arith = 1'b0;
    cls_logic = 1'b0;
    cls_bcd   = 1'b0;
    op_writes = 1'b0;
    unique case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_INC, OP_DEC: begin cls_arith = 1'b1; op_writes = 1'b1; end
      OP_CP:                                         cls_arith = 1'b1;
      OP_AND, OP_XOR, OP_OR, OP_CPL:                 begin cls_logic = 1'b1; op_writes = 1'b1; end
      OP_SCF, OP_CCF:                                cls_logic = 1'b1;
      OP_DAA:                                        begin cls_bcd = 1'b1; op_writes = 1'b1; end
      default: ;
    endcase
  end

  alu_arith u_arith (
    .op       (op),
    .a        (opnd_a),
    .b        (opnd_b),
    .c_in     (flg_q.c),
    .res      (ar_res),
    .flg      (ar_flg),
    .half_ev  (ar_half),
    .carry_ev (ar_carry)
  );

  alu_logic u_logic (
    .op   (op),
    .a    (opnd_a),
    .b    (opnd_b),
    .z_in (flg_q.z),
    .c_in (flg_q.c),
    .res  (lg_res),
    .flg  (lg_flg)
  );

  alu_bcd u_bcd (
    .a      (opnd_a),
    .n_in   (flg_q.n),
    .h_in   (flg_q.h),
    .c_in   (flg_q.c),
    .res    (bc_res),
    .flg    (bc_flg),
    .offset (bc_ofs)
  );

  always_comb begin
    result  = opnd_a;
    flg_nxt = flg_q;
    if (cls_arith) begin
      result  = ar_res;
      flg_nxt = ar_flg;
    end else if (cls_logic) begin
      result  = lg_res;
      flg_nxt = lg_flg;
    end else if (cls_bcd) begin
      result  = bc_res;
      flg_nxt = bc_flg;
    end
  end

  assign result_we = op_valid & op_writes;
  assign flag_next = {flg_nxt, {PAD{1'b0}}};
  assign flag_byte = {flg_q, {PAD{1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         flg_q <= FLAGS_RST;
    else if (flag_load) flg_q <= flag_wdata[W-1 -: FLW];
    else if (op_valid)  flg_q <= flg_nxt;
  end

  // Assertions beside the flag register
  AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid && !flag_load) |=> $stable(flg_q)); // R10

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    flag_load |=> (flg_q == $past(flag_wdata[W-1 -: FLW]))); // R11

  AST_INCDEC_KEEP_C: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !flag_load && (op == OP_INC || op == OP_DEC)) |=> (flg_q.c == $past(flg_q.c))); // R5

  AST_CCF_FLIPS_C: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !flag_load && op == OP_CCF) |=> (flg_q.c != $past(flg_q.c))); // R6

  AST_ADD_CLEARS_N: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !flag_load && (op == OP_ADD || op == OP_ADC)) |=> (!flg_q.n && flg_q.c == $past(ar_carry) && flg_q.h == $past(ar_half))); // R1

  AST_CP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op == OP_CP) |-> !result_we); // R3

  AST_DAA_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_bcd && !flg_q.h && !flg_q.c && flg_q.n) |-> (bc_ofs == '0)); // R7

endmodule

// File: tb/acc_alu_tb.sv
module acc_alu_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [3:0] op_code = '0;
  logic [7:0] opnd_a = '0;
  logic [7:0] opnd_b = '0;
  logic       flag_load = 1'b0;
  logic [7:0] flag_wdata = '0;
  logic [7:0] result;
  logic       result_we;
  logic [7:0] flag_next;
  logic [7:0] flag_byte;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  acc_alu u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .op_code    (op_code),
    .opnd_a     (opnd_a),
    .opnd_b     (opnd_b),
    .flag_load  (flag_load),
    .flag_wdata (flag_wdata),
    .result     (result),
    .result_we  (result_we),
    .flag_next  (flag_next),
    .flag_byte  (flag_byte)
  );

  // {req, op, a, b, flags_in(ZNHC), exp_result, exp_we, exp_flags(ZNHC)}
  localparam int NV = 26;
  localparam logic [40:0] VEC [NV] = '{
    {4'd1,  4'd0,  8'h3A, 8'hC6, 4'h0, 8'h00, 1'b1, 4'hB},
    {4'd1,  4'd0,  8'h0F, 8'h01, 4'h0, 8'h10, 1'b1, 4'h2},
    {4'd1,  4'd1,  8'hE1, 8'h0F, 4'h1, 8'hF1, 1'b1, 4'h2},
    {4'd2,  4'd2,  8'h3E, 8'h3E, 4'h0, 8'h00, 1'b1, 4'hC},
    {4'd2,  4'd2,  8'h3E, 8'h40, 4'h0, 8'hFE, 1'b1, 4'h5},
    {4'd2,  4'd3,  8'h3B, 8'h2A, 4'h1, 8'h10, 1'b1, 4'h4},
    {4'd2,  4'd3,  8'h10, 8'h00, 4'h1, 8'h0F, 1'b1, 4'h6},
    {4'd3,  4'd7,  8'h3C, 8'h2F, 4'h0, 8'h0D, 1'b0, 4'h6},
    {4'd4,  4'd4,  8'h5A, 8'h3F, 4'hF, 8'h1A, 1'b1, 4'h2},
    {4'd4,  4'd4,  8'hF0, 8'h0F, 4'h0, 8'h00, 1'b1, 4'hA},
    {4'd4,  4'd5,  8'hFF, 8'hFF, 4'hF, 8'h00, 1'b1, 4'h8},
    {4'd4,  4'd6,  8'h12, 8'h81, 4'h7, 8'h93, 1'b1, 4'h0},
    {4'd5,  4'd8,  8'h00, 8'hFF, 4'h1, 8'h00, 1'b1, 4'hB},
    {4'd5,  4'd8,  8'h00, 8'h0F, 4'h0, 8'h10, 1'b1, 4'h2},
    {4'd5,  4'd9,  8'h00, 8'h01, 4'h0, 8'h00, 1'b1, 4'hC},
    {4'd5,  4'd9,  8'h00, 8'h10, 4'h1, 8'h0F, 1'b1, 4'h7},
    {4'd6,  4'd10, 8'h35, 8'h00, 4'h9, 8'hCA, 1'b1, 4'hF},
    {4'd6,  4'd11, 8'h22, 8'h00, 4'hE, 8'h22, 1'b0, 4'h9},
    {4'd6,  4'd12, 8'h44, 8'h00, 4'h1, 8'h44, 1'b0, 4'h0},
    {4'd6,  4'd12, 8'h44, 8'h00, 4'h8, 8'h44, 1'b0, 4'h9},
    {4'd7,  4'd13, 8'h7D, 8'h00, 4'h0, 8'h83, 1'b1, 4'h0},
    {4'd7,  4'd13, 8'h9A, 8'h00, 4'h0, 8'h00, 1'b1, 4'h9},
    {4'd7,  4'd13, 8'h0F, 8'h00, 4'h6, 8'h09, 1'b1, 4'h4},
    {4'd7,  4'd13, 8'hA0, 8'h00, 4'h5, 8'h40, 1'b1, 4'h5},
    {4'd7,  4'd13, 8'h9F, 8'h00, 4'h4, 8'h9F, 1'b1, 4'h4},
    {4'd12, 4'd14, 8'h5C, 8'h00, 4'h5, 8'h5C, 1'b0, 4'h5}
  };

  function automatic string rq(input logic [3:0] n);
    case (n)
      4'd1:  return "R1";
      4'd2:  return "R2";
      4'd3:  return "R3";
      4'd4:  return "R4";
      4'd5:  return "R5";
      4'd6:  return "R6";
      4'd7:  return "R7";
      4'd12: return "R12";
      default: return "R?";
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [7:0] act,
                       input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic load_flags(input logic [7:0] v);
    @(negedge clk);
    op_valid   = 1'b0;
    flag_load  = 1'b1;
    flag_wdata = v;
    @(negedge clk);
    flag_load  = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    // Reset value before release (R10)
    check("R10", "reset flag_byte", flag_byte, 8'hB0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", "flag_byte after release", flag_byte, 8'hB0);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      logic [40:0] v;
      string r;
      v = VEC[i];
      r = rq(v[40:37]);
      load_flags({v[16:13], 4'h0});
      op_code  = v[36:33];
      opnd_a   = v[32:25];
      opnd_b   = v[24:17];
      op_valid = 1'b1;
      #1;
      check(r, $sformatf("vec%0d result", i), result, v[12:5]);
      check(r, $sformatf("vec%0d result_we", i), {7'd0, result_we}, {7'd0, v[4]});
      check(r, $sformatf("vec%0d flag_next", i), flag_next, {v[3:0], 4'h0});
      @(negedge clk);
      op_valid = 1'b0;
      check(r, $sformatf("vec%0d flag_byte", i), flag_byte, {v[3:0], 4'h0});
    end

    // R8 / R9: packed layout, low nibble ignored on load and read as zero
    load_flags(8'hFF);
    check("R9", "load FF low nibble", flag_byte, 8'hF0);
    load_flags(8'h5A);
    check("R8", "load 5A bit layout", flag_byte, 8'h50);
    // C at bit 4 used as carry-in: ADC 00+00 with only bit 4 set gives 01
    load_flags(8'h1F);
    op_code = 4'd1; opnd_a = 8'h00; opnd_b = 8'h00; op_valid = 1'b1;
    #1;
    check("R8", "bit4 is carry-in", result, 8'h01);
    check("R9", "flag_next low nibble", flag_next & 8'h0F, 8'h00);
    @(negedge clk);
    op_valid = 1'b0;

    // R10: no strobe, no change; result_we low
    load_flags(8'h20);
    op_code = 4'd0; opnd_a = 8'h3A; opnd_b = 8'hC6; op_valid = 1'b0;
    #1;
    check("R10", "result_we without strobe", {7'd0, result_we}, 8'h00);
    @(negedge clk);
    @(negedge clk);
    check("R10", "flags hold without strobe", flag_byte, 8'h20);

    // R11: load wins over a simultaneous operation
    @(negedge clk);
    op_code = 4'd4; opnd_a = 8'hF0; opnd_b = 8'h0F; op_valid = 1'b1;
    flag_load = 1'b1; flag_wdata = 8'h10;
    #1;
    check("R11", "result_we during load", {7'd0, result_we}, 8'h01);
    check("R11", "result during load", result, 8'h00);
    @(negedge clk);
    op_valid = 1'b0; flag_load = 1'b0;
    check("R11", "load beats op", flag_byte, 8'h10);

    // R12: code 15 no-op
    load_flags(8'hA0);
    op_code = 4'd15; opnd_a = 8'h77; op_valid = 1'b1;
    #1;
    check("R12", "code15 result", result, 8'h77);
    check("R12", "code15 result_we", {7'd0, result_we}, 8'h00);
    @(negedge clk);
    op_valid = 1'b0;
    check("R12", "code15 flags kept", flag_byte, 8'hA0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule